// File: doc/BRIEF.md
# Debug System-Bus Access Master

This block lets a debugger reach system memory without involving a processor. It sits behind a small register port: a 7-bit register address, 32-bit write data, and one-cycle read and write strobes. Through this port the debugger sees a control/status register, four address registers and four data registers. The block turns register accesses into single reads or writes on a generic request/response memory bus.

Bus accesses are never commanded explicitly. They start as side effects of register traffic:
- Writing the low address register can start a read.
- Reading the low data register can start the next read.
- Writing the low data register always starts a write.

With automatic address increment enabled, a debugger can stream through memory using nothing but data-register accesses. The block tracks a busy flag and keeps a sticky error code. It refuses any access that is misaligned or of an unsupported width. It also gives up on a bus that does not answer within a configurable number of cycles.

This build supports 8, 16 and 32-bit accesses and a 32-bit address.

Top module: `sysbus_dbg_master`

## Requirements
- R1: The control/status register is at 0x38. After reset it reads 0x20040407:
  - bits 31:29 hold the interface revision, which is 1;
  - bits 11:5 hold the address width, which is 32;
  - bits 4:0 are the support flags for 128/64/32/16/8-bit accesses, most significant first, reading 00111;
  - the size field resets to 2.
- R2: Bit 21 (busy) reads 1 from the first cycle after a register access that starts a bus access. It returns to 0 once the response, or the timeout, has been taken.
- R3: With bit 20 set, a write to the low address register 0x39 loads the address and issues a bus read at the new address.
- R4: Bits 19:17 select the size: 0=8, 1=16, 2=32, 3=64, 4=128 bits. If an access starts with a size above 2, or with an address not aligned to the size, no bus request is issued and the error field becomes 3.
- R5: Bits 14:12 hold the error code:
  - 0: none;
  - 1: timeout;
  - 2: bus error;
  - 3: size or alignment;
  - 4: touched while busy.

  The first nonzero code is kept until it is cleared. Writing ones to these bits of 0x38 clears them.
- R6: With bit 15 set, a read of the low data register 0x3C returns the current data and issues the next bus read.
- R7: With bit 16 set, the address advances by the access size in bytes after each access that completes without error.
- R8: A write to 0x3C loads the data and issues a bus write of that data at the current address and size.
- R9: While busy, any of the following has no effect on the address or data and sets error 4 if no error is held:
  - a write to an address register (0x37, 0x39–0x3B);
  - any read or write of a data register (0x3C–0x3F).
- R10: While the error field is nonzero, no bus access is started.
- R11: A bus access that gets no response within TIMEOUT_CYC cycles ends with error 1. A response flagged as an error ends with error 2, and the data register is left unchanged.
- R12: A successful read places the bus data into 0x3C. Registers 0x37, 0x3A, 0x3B, 0x3D–0x3F read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| bus_req_valid | output | 1 | One-cycle bus request pulse |
| bus_req_write | output | 1 | Request is a write |
| bus_req_addr | output | 32 | Request byte address |
| bus_req_size | output | 3 | Request size code |
| bus_req_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | Response strobe |
| bus_rsp_err | input | 1 | Response carries an error |
| bus_rsp_rdata | input | 32 | Read data |

## Verification
Most internal faults reach the bus request port within one cycle of the triggering register access. Examples are a busy flag that sticks, a missed trigger, or a bad alignment decision. Each shows up as a missing, extra or mis-addressed request pulse, which the reference model compares on every clock.

Corruption of the address, the data or the error code surfaces on the next read of 0x38, 0x39 or 0x3C. Increment, sticky-error and timeout faults therefore appear at most one access later.

// File: rtl/sbm_pkg.sv
// Shared constants for the debug system-bus master.
// Assumes a 7-bit register address space; only the offsets below decode.
package sbm_pkg;
    localparam logic [6:0] RA_ADDR3 = 7'h37;
    localparam logic [6:0] RA_CTRL  = 7'h38;
    localparam logic [6:0] RA_ADDR0 = 7'h39;
    localparam logic [6:0] RA_ADDR1 = 7'h3A;
    localparam logic [6:0] RA_ADDR2 = 7'h3B;
    localparam logic [6:0] RA_DATA0 = 7'h3C;
    localparam logic [6:0] RA_DATA1 = 7'h3D;
    localparam logic [6:0] RA_DATA2 = 7'h3E;
    localparam logic [6:0] RA_DATA3 = 7'h3F;

    localparam logic [2:0] ERR_NONE    = 3'd0;
    localparam logic [2:0] ERR_TIMEOUT = 3'd1;
    localparam logic [2:0] ERR_BUS     = 3'd2;
    localparam logic [2:0] ERR_OTHER   = 3'd3;
    localparam logic [2:0] ERR_BUSY    = 3'd4;

    localparam logic [2:0] IF_REVISION = 3'd1;

    // Bytes moved by an access of the given size code.
    function automatic logic [7:0] size_bytes(input logic [2:0] sz);
        return 8'd1 << sz;
    endfunction
endpackage

// File: rtl/sbm_access_check.sv
// Legality check for a bus access about to start.
// Combinational: the size must be implemented and the address naturally aligned.
// Assumes size codes up to 7, so at most 7 low address bits matter.
module sbm_access_check #(
    parameter int MAX_SZ_LOG2 = 2
) (
    input  logic [2:0] size_i,
    input  logic [6:0] addr_lo_i,
    output logic       ok_o
);
    logic size_ok;
    logic misaligned;

    // Decide whether the size is implemented and the address is aligned to it.
    always_comb begin
        size_ok    = (int'(size_i) <= MAX_SZ_LOG2);
        misaligned = 1'b0;
        for (int i = 0; i < 7; i++) begin
            if ((i < int'(size_i)) && addr_lo_i[i]) misaligned = 1'b1;
        end
        ok_o = size_ok && !misaligned;
    end
endmodule

// File: rtl/sbm_bus_engine.sv
// Bus sequencer: issues one request pulse, then waits for a response or a timeout.
// Assumes go_i arrives only while idle. Request fields stay stable while waiting.
module sbm_bus_engine #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              go_write_i,
    input  logic [ADDR_W-1:0] go_addr_i,
    input  logic [2:0]        go_size_i,
    input  logic [DATA_W-1:0] go_wdata_i,
    output logic              busy_o,
    output logic              fin_o,
    output logic [2:0]        fin_code_o,
    output logic              bus_req_valid,
    output logic              bus_req_write,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [2:0]        bus_req_size,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_rsp_valid,
    input  logic              bus_rsp_err
);
    import sbm_pkg::*;

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef enum logic { ST_IDLE, ST_WAIT } eng_st_e;

    eng_st_e          st_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy_o = (st_q == ST_WAIT);

    // Completion happens on a response or when the wait window runs out.
    always_comb begin
        fin_o      = 1'b0;
        fin_code_o = ERR_NONE;
        if (st_q == ST_WAIT) begin
            if (bus_rsp_valid) begin
                fin_o      = 1'b1;
                fin_code_o = bus_rsp_err ? ERR_BUS : ERR_NONE;
            end else if (cnt_q == CNT_LAST) begin
                fin_o      = 1'b1;
                fin_code_o = ERR_TIMEOUT;
            end
        end
    end

    // State, wait counter and the registered request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= ST_IDLE;
            cnt_q         <= '0;
            bus_req_valid <= 1'b0;
            bus_req_write <= 1'b0;
            bus_req_addr  <= '0;
            bus_req_size  <= '0;
            bus_req_wdata <= '0;
        end else begin
            bus_req_valid <= 1'b0;
            if (st_q == ST_IDLE) begin
                if (go_i) begin
                    st_q          <= ST_WAIT;
                    cnt_q         <= '0;
                    bus_req_valid <= 1'b1;
                    bus_req_write <= go_write_i;
                    bus_req_addr  <= go_addr_i;
                    bus_req_size  <= go_size_i;
                    bus_req_wdata <= go_wdata_i;
                end
            end else if (fin_o) begin
                st_q <= ST_IDLE;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    a_r2_req_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> busy_o);
    a_r8_req_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |=> !bus_req_valid);
    a_r11_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt_q <= CNT_LAST));
    a_r2_fin_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !busy_o);
endmodule

// File: rtl/sysbus_dbg_master.sv
// Debug system-bus master top: register decode, access triggering, error and
// address bookkeeping. Assumes reg_wr and reg_rd are never high together.
// reg_rdata is combinational from reg_addr; read side effects act on reg_rd.
module sysbus_dbg_master #(
    parameter int ADDR_W      = 32,
    parameter int TIMEOUT_CYC = 16,
    parameter int MAX_SZ_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [31:0]       reg_rdata,
    output logic              bus_req_valid,
    output logic              bus_req_write,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [2:0]        bus_req_size,
    output logic [31:0]       bus_req_wdata,
    input  logic              bus_rsp_valid,
    input  logic              bus_rsp_err,
    input  logic [31:0]       bus_rsp_rdata
);
    import sbm_pkg::*;

    localparam int DATA_W = 32;
    localparam logic [4:0] SIZE_CAPS = 5'((1 << (MAX_SZ_LOG2 + 1)) - 1);
    localparam logic [6:0] ASIZE     = 7'(ADDR_W);

    logic              rd_on_addr_q, rd_on_data_q, inc_q;
    logic [2:0]        size_q, err_q, err_nxt;
    logic [ADDR_W-1:0] addr_q, chk_addr;
    logic [DATA_W-1:0] data_q, go_wdata;
    logic              busy, fin, access_ok;
    logic [2:0]        fin_code;
    logic              is_addr_reg, is_data_reg, ctrl_wr, touch;
    logic              trig_rd_addr, trig_rd_data, trig_wr, want, go, bad;

    // Classify the current register access and derive the trigger conditions.
    always_comb begin
        is_addr_reg  = (reg_addr == RA_ADDR0) || (reg_addr == RA_ADDR1) ||
                       (reg_addr == RA_ADDR2) || (reg_addr == RA_ADDR3);
        is_data_reg  = (reg_addr == RA_DATA0) || (reg_addr == RA_DATA1) ||
                       (reg_addr == RA_DATA2) || (reg_addr == RA_DATA3);
        ctrl_wr      = reg_wr && (reg_addr == RA_CTRL);
        touch        = busy && ((reg_wr && (is_addr_reg || is_data_reg)) ||
                                (reg_rd && is_data_reg));
        trig_rd_addr = !busy && reg_wr && (reg_addr == RA_ADDR0) && rd_on_addr_q;
        trig_rd_data = !busy && reg_rd && (reg_addr == RA_DATA0) && rd_on_data_q;
        trig_wr      = !busy && reg_wr && (reg_addr == RA_DATA0);
        want         = (trig_rd_addr || trig_rd_data || trig_wr) && (err_q == ERR_NONE);
        chk_addr     = trig_rd_addr ? reg_wdata[ADDR_W-1:0] : addr_q;
        go_wdata     = trig_wr ? reg_wdata : data_q;
        go           = want && access_ok;
        bad          = want && !access_ok;
    end

    sbm_access_check #(.MAX_SZ_LOG2(MAX_SZ_LOG2)) u_check (
        .size_i    (size_q),
        .addr_lo_i (chk_addr[6:0]),
        .ok_o      (access_ok)
    );

    sbm_bus_engine #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .go_i          (go),
        .go_write_i    (trig_wr),
        .go_addr_i     (chk_addr),
        .go_size_i     (size_q),
        .go_wdata_i    (go_wdata),
        .busy_o        (busy),
        .fin_o         (fin),
        .fin_code_o    (fin_code),
        .bus_req_valid (bus_req_valid),
        .bus_req_write (bus_req_write),
        .bus_req_addr  (bus_req_addr),
        .bus_req_size  (bus_req_size),
        .bus_req_wdata (bus_req_wdata),
        .bus_rsp_valid (bus_rsp_valid),
        .bus_rsp_err   (bus_rsp_err)
    );

    // Next error code: bus outcome, then software clear, then busy touch, then legality.
    always_comb begin
        err_nxt = err_q;
        if (fin && (fin_code != ERR_NONE) && (err_nxt == ERR_NONE)) err_nxt = fin_code;
        if (ctrl_wr) err_nxt = err_nxt & ~reg_wdata[14:12];
        if (touch && (err_nxt == ERR_NONE)) err_nxt = ERR_BUSY;
        if (bad) err_nxt = ERR_OTHER;
    end

    // Configuration, error, address and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_on_addr_q <= 1'b0;
            rd_on_data_q <= 1'b0;
            inc_q        <= 1'b0;
            size_q       <= 3'd2;
            err_q        <= ERR_NONE;
            addr_q       <= '0;
            data_q       <= '0;
        end else begin
            err_q <= err_nxt;
            if (ctrl_wr) begin
                rd_on_addr_q <= reg_wdata[20];
                size_q       <= reg_wdata[19:17];
                inc_q        <= reg_wdata[16];
                rd_on_data_q <= reg_wdata[15];
            end
            if (fin && (fin_code == ERR_NONE)) begin
                if (!bus_req_write) data_q <= bus_rsp_rdata;
                if (inc_q) addr_q <= addr_q + ADDR_W'(size_bytes(bus_req_size));
            end
            if (!busy && reg_wr && (reg_addr == RA_ADDR0)) addr_q <= reg_wdata[ADDR_W-1:0];
            if (!busy && reg_wr && (reg_addr == RA_DATA0)) data_q <= reg_wdata;
        end
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:  reg_rdata = {IF_REVISION, 7'd0, busy, rd_on_addr_q, size_q,
                                   inc_q, rd_on_data_q, err_q, ASIZE, SIZE_CAPS};
            RA_ADDR0: reg_rdata = 32'(addr_q);
            RA_DATA0: reg_rdata = data_q;
            default:  reg_rdata = '0;
        endcase
    end

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != ERR_NONE) && !ctrl_wr |=> (err_q == $past(err_q)));
    a_r10_no_req_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != ERR_NONE) |=> !bus_req_valid);
    a_r4_req_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> ((int'(bus_req_size) <= MAX_SZ_LOG2) &&
        ((bus_req_addr & (ADDR_W'(size_bytes(bus_req_size)) - 1'b1)) == '0)));
    a_r9_touch_flags: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (err_q != ERR_NONE));
    a_r7_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
        fin && (fin_code == ERR_NONE) && inc_q |=>
        (addr_q == $past(addr_q) + ADDR_W'(size_bytes($past(bus_req_size)))));
endmodule

// File: tb/tb_sysbus_dbg_master.sv
`timescale 1ns/1ps
module tb_sysbus_dbg_master;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        bus_req_valid, bus_req_write;
    logic [31:0] bus_req_addr, bus_req_wdata;
    logic [2:0]  bus_req_size;
    logic        bus_rsp_valid = 1'b0, bus_rsp_err = 1'b0;
    logic [31:0] bus_rsp_rdata = '0;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    sysbus_dbg_master #(.ADDR_W(32), .TIMEOUT_CYC(TMO), .MAX_SZ_LOG2(2)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
        .bus_req_addr(bus_req_addr), .bus_req_size(bus_req_size),
        .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
        .bus_rsp_err(bus_rsp_err), .bus_rsp_rdata(bus_rsp_rdata));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // ---------------- memory responder ----------------
    logic [31:0] mem [16];
    int          lat = 3, cd = 0;
    logic        err_mode = 1'b0, pend_w = 1'b0;
    logic [31:0] pend_a = '0, pend_d = '0;

    initial for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0101;

    always @(negedge clk) begin
        bus_rsp_valid = 1'b0;
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                bus_rsp_valid = 1'b1;
                bus_rsp_err   = err_mode;
                bus_rsp_rdata = pend_w ? 32'h0 : mem[pend_a[5:2]];
                if (pend_w && !err_mode) mem[pend_a[5:2]] = pend_d;
            end
        end
        if (bus_req_valid) begin
            cd = lat; pend_a = bus_req_addr; pend_w = bus_req_write; pend_d = bus_req_wdata;
        end
    end

    // ---------------- behavioural reference model ----------------
    logic        m_busy, m_roa, m_inc, m_rod, m_cur_wr, m_req_v, m_req_w;
    int          m_cnt;
    logic [2:0]  m_err, m_size, m_cur_size, m_req_s;
    logic [31:0] m_addr, m_data, m_req_a, m_req_d;

    function automatic logic is_reg_slot(input logic [6:0] a);
        return (a == 7'h37) || (a >= 7'h39 && a <= 7'h3F);
    endfunction

    always @(posedge clk) begin : model
        logic fin, sr, sw;
        logic [2:0] code, e;
        logic [31:0] a, d;
        int nb;
        if (!rst_n) begin
            m_busy <= 0; m_roa <= 0; m_inc <= 0; m_rod <= 0; m_cur_wr <= 0;
            m_req_v <= 0; m_req_w <= 0; m_cnt <= 0; m_err <= 0; m_size <= 3'd2;
            m_cur_size <= 0; m_req_s <= 0; m_addr <= 0; m_data <= 0; m_req_a <= 0; m_req_d <= 0;
        end else begin
            fin = 0; code = 0; e = m_err; a = m_addr; d = m_data; sr = 0; sw = 0;
            m_req_v <= 0;
            if (m_busy) begin
                if (bus_rsp_valid) begin fin = 1; code = bus_rsp_err ? 3'd2 : 3'd0; end
                else if (m_cnt == TMO - 1) begin fin = 1; code = 3'd1; end
                else m_cnt <= m_cnt + 1;
            end
            if (fin) begin
                m_busy <= 0;
                if (code != 0) begin if (e == 0) e = code; end
                else begin
                    if (!m_cur_wr) d = bus_rsp_rdata;
                    if (m_inc) a = a + (32'd1 << m_cur_size);
                end
            end
            if (reg_wr && reg_addr == 7'h38) begin
                m_roa <= reg_wdata[20]; m_size <= reg_wdata[19:17];
                m_inc <= reg_wdata[16]; m_rod <= reg_wdata[15];
                e = e & ~reg_wdata[14:12];
            end else if (m_busy && ((reg_wr && is_reg_slot(reg_addr)) ||
                                    (reg_rd && reg_addr >= 7'h3C && reg_addr <= 7'h3F))) begin
                if (e == 0) e = 3'd4;
            end else if (!m_busy) begin
                if (reg_wr && reg_addr == 7'h39) begin a = reg_wdata; sr = m_roa; end
                if (reg_wr && reg_addr == 7'h3C) begin d = reg_wdata; sw = 1; end
                if (reg_rd && reg_addr == 7'h3C) sr = m_rod;
            end
            if ((sr || sw) && m_err == 0) begin
                nb = 1 << m_size;
                if (m_size > 2 || (int'(a[3:0]) % nb) != 0) e = 3'd3;
                else begin
                    m_busy <= 1; m_cnt <= 0; m_req_v <= 1; m_req_a <= a; m_req_w <= sw;
                    m_req_d <= d; m_req_s <= m_size; m_cur_size <= m_size; m_cur_wr <= sw;
                end
            end
            m_err <= e; m_addr <= a; m_data <= d;
        end
    end

    function automatic logic [31:0] model_rd(input logic [6:0] a);
        case (a)
            7'h38:   return {3'd1, 7'd0, m_busy, m_roa, m_size, m_inc, m_rod, m_err, 7'd32, 5'b00111};
            7'h39:   return m_addr;
            7'h3C:   return m_data;
            default: return 32'h0;
        endcase
    endfunction

    // Every clock: the bus request port must match the model (R2, R3, R6, R8, R10).
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R10 req_valid", {31'd0, bus_req_valid}, {31'd0, m_req_v});
            if (m_req_v) begin
                chk("R3 req_addr", bus_req_addr, m_req_a);
                chk("R8 req_write", {31'd0, bus_req_write}, {31'd0, m_req_w});
                chk("R4 req_size", {29'd0, bus_req_size}, {29'd0, m_req_s});
                if (m_req_w) chk("R8 req_wdata", bus_req_wdata, m_req_d);
            end
        end
    end

    // ---------------- register access tasks (start and end at a negedge) ----------------
    task automatic op_wr(input logic [6:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic op_rd(input logic [6:0] a, input string tag, output logic [31:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        chk(tag, v, model_rd(a));
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset value and layout
        op_rd(7'h38, "R1 ctrl", v);  chk("R1 reset literal", v, 32'h2004_0407);
        // R12 upper slots read zero
        op_rd(7'h37, "R12 addr3", v); op_rd(7'h3A, "R12 addr1", v); op_rd(7'h3F, "R12 data3", v);

        // R3 read on address write, 32-bit, increment on
        op_wr(7'h38, 32'h0015_0000);
        op_wr(7'h39, 32'h10);
        op_rd(7'h38, "R2 busy", v);   chk("R2 busy bit", {31'd0, v[21]}, 32'd1);
        wait_idle();
        op_rd(7'h38, "R2 idle", v);   chk("R2 busy low", {31'd0, v[21]}, 32'd0);
        op_rd(7'h3C, "R12 data", v);  chk("R3 read value", v, 32'h1404_0404);
        op_rd(7'h39, "R7 addr", v);   chk("R7 incremented", v, 32'h14);

        // R8 write at 0x14, then read it back
        op_wr(7'h38, 32'h0005_0000);
        op_wr(7'h3C, 32'hCAFE_0001);
        wait_idle();
        op_rd(7'h39, "R7 addr", v);   chk("R7 after write", v, 32'h18);
        op_wr(7'h38, 32'h0014_0000);
        op_wr(7'h39, 32'h14);
        wait_idle();
        op_rd(7'h3C, "R8 data", v);   chk("R8 written value", v, 32'hCAFE_0001);

        // R9 touch while busy
        lat = 6;
        op_wr(7'h39, 32'h20);
        op_wr(7'h39, 32'h30);
        op_rd(7'h38, "R9 ctrl", v);   chk("R9 err4", {29'd0, v[14:12]}, 32'd4);
        wait_idle();
        op_rd(7'h39, "R9 addr", v);   chk("R9 addr kept", v, 32'h20);

        // R10 no access while an error is held, R5 sticky
        op_wr(7'h39, 32'h8);
        op_rd(7'h38, "R10 ctrl", v);  chk("R5 sticky", {29'd0, v[14:12]}, 32'd4);
        chk("R10 not busy", {31'd0, v[21]}, 32'd0);
        op_wr(7'h38, 32'h0014_7000);
        op_rd(7'h38, "R5 clear", v);  chk("R5 w1c", {29'd0, v[14:12]}, 32'd0);

        // R4 unsupported size and misalignment
        op_wr(7'h38, 32'h001A_0000);
        op_wr(7'h39, 32'h0);
        op_rd(7'h38, "R4 ctrl", v);   chk("R4 size err", {29'd0, v[14:12]}, 32'd3);
        op_wr(7'h38, 32'h0014_7000);
        op_wr(7'h39, 32'h6);
        op_rd(7'h38, "R4 ctrl", v);   chk("R4 align err", {29'd0, v[14:12]}, 32'd3);
        op_wr(7'h38, 32'h0012_7000);
        op_wr(7'h39, 32'h6);
        wait_idle();
        op_rd(7'h38, "R4 ctrl", v);   chk("R4 16-bit ok", {29'd0, v[14:12]}, 32'd0);
        op_wr(7'h38, 32'h0010_0000);
        op_wr(7'h39, 32'h3);
        wait_idle();
        op_rd(7'h3C, "R4 byte data", v);

        // R6 streaming with read-on-data
        op_wr(7'h38, 32'h0015_8000);
        op_wr(7'h39, 32'h0);
        wait_idle();
        for (int i = 0; i < 3; i++) begin
            op_rd(7'h3C, "R6 stream", v);
            chk("R6 stream value", v, mem[i]);
            wait_idle();
        end
        op_rd(7'h39, "R7 addr", v);   chk("R7 stream end", v, 32'h10);

        // R11 timeout, then bus error
        lat = 40;
        op_wr(7'h38, 32'h0014_0000);
        op_wr(7'h39, 32'h0);
        wait_idle();
        op_rd(7'h38, "R11 ctrl", v);  chk("R11 timeout", {29'd0, v[14:12]}, 32'd1);
        repeat (50) @(negedge clk);
        lat = 3;
        op_wr(7'h38, 32'h0014_7000);
        err_mode = 1'b1;
        op_wr(7'h39, 32'h4);
        wait_idle();
        op_rd(7'h38, "R11 ctrl", v);  chk("R11 bus err", {29'd0, v[14:12]}, 32'd2);
        op_rd(7'h3C, "R11 data kept", v);
        err_mode = 1'b0;
        op_wr(7'h38, 32'h0014_7000);
        op_rd(7'h38, "R5 clear", v);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule